// File: doc/BRIEF.md
# Overcharge Delay Timer Controller

This block is the digital decision core of a protector for a stack of up to five series cells. For each cell, external comparators supply two flags: one that says the cell is above its detect threshold, and one that says the cell is below its release level. The release level is the detect threshold plus a negative hysteresis. The block turns these flags into one charge-control output. It enters overcharge status only after a cell has stayed above its threshold for a selectable detection delay. It returns to normal status only after every cell has stayed below its release level for a short debounce time.

The detection timer tolerates noise. A dip that leaves no cell above the threshold keeps the count running unless the dip lasts for the whole timer-reset window. A dip of that length clears the count. A test request held long enough sets a latch that shortens only the detection delay. The latch clears as soon as overcharge is reached, or when undervoltage lockout is flagged.

All time is counted in pulses of a prescaled `tick` input. Every duration is a parameter in ticks, so a bench can shrink the real values: seconds for detection, about 12 ms for the reset window, 2 ms for release and 32 ms for the test delay. All inputs are taken as synchronous to `clk`.

Top module: `ovc_delay_ctrl`

## Requirements
- R1: With the test latch clear, overcharge status is entered on the tick on which the above-threshold flags have had at least one cell set for DET_UNIT×2^`dly_sel` counted ticks (code 0/1/2/3 gives 1/2/4/8 units), and not before. Any cell's flag counts.
- R2: While a count is running, a dip in which no above-threshold flag is set keeps the count if the dip is shorter than TR_WIN ticks. The count resumes from its value when any flag is set again.
- R3: A dip of TR_WIN ticks with no above-threshold flag clears the count. Detection then needs the full delay again, counted from the next tick with a flag set.
- R4: From overcharge status, the block returns to normal on the REL-th consecutive tick on which every cell's below-release flag (`below_rel`, bit n for cell n) is set.
- R5: In overcharge status, a tick on which any cell's below-release flag is clear keeps the overcharge status and restarts the release debounce from zero.
- R6: The test latch sets on the TST_ENTRY-th consecutive tick with `test_req` high, and stays set after `test_req` falls. A request of fewer ticks, or one that is broken, does not set it.
- R7: While the test latch is set, the detection delay is TST_DET ticks whatever `dly_sel` is. The reset window stays TR_WIN ticks.
- R8: The test latch clears on entry to overcharge status. A later detection then uses the full delay.
- R9: `uvlo` high at a clock edge forces normal status and clears the detection count, the dip count, the release count and the test latch.
- R10: `chg_ctl_o` is high in overcharge status and low in normal status when `act_low` is 0. It is the inverse when `act_low` is 1.
- R11: After `rst_n` is asserted, the block is in normal status with all counts and the test latch clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled time-base pulse, one clock wide |
| above_det | input | NCELL | Per-cell flag: cell above its detect threshold |
| below_rel | input | NCELL | Per-cell flag: cell below its release level |
| test_req | input | 1 | Test-mode request |
| uvlo | input | 1 | Undervoltage lockout, synchronous clear |
| dly_sel | input | 2 | Detection delay code (1, 2, 4 or 8 units) |
| act_low | input | 1 | Output polarity select |
| chg_ctl_o | output | 1 | Charge-control output |

## Verification
The assertions assume that `tick` is a single-clock pulse and that the comparator flags change only between ticks. They also assume that a cell is never flagged as both above its detect threshold and below its release level at the same time. The stimulus keeps to these rules. It changes flags only at a falling clock edge with `tick` low, and it raises each tick for one clock with an idle clock after it. It always pairs a set above-threshold flag with a clear below-release flag for that cell. `uvlo` is pulsed only between ticks, so its effect shows apart from any tick-driven transition.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
  typedef enum logic {
    ST_NORMAL = 1'b0,
    ST_OVER   = 1'b1
  } ovc_state_e;
endpackage

// File: rtl/ovc_det_timer.sv
module ovc_det_timer #(
  parameter int DET_UNIT = 1000,
  parameter int TR_WIN   = 12,
  parameter int TST_DET  = 32,
  parameter int CNT_W    = 14,
  parameter int WIN_W    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo,
  input  logic       tick,
  input  logic       run,
  input  logic       any_above,
  input  logic       test_on,
  input  logic [1:0] dly_sel,
  output logic       det_hit
);
  localparam logic [CNT_W-1:0] LIM_TST = CNT_W'(TST_DET);
  localparam logic [WIN_W-1:0] LIM_WIN = WIN_W'(TR_WIN);

  logic [CNT_W-1:0] cnt_q, cnt_nx, cnt_inc, limit;
  logic [WIN_W-1:0] dip_q, dip_nx, dip_inc;
  logic             armed_q, armed_nx;
  logic             upd_en;

  always_comb begin
    if (test_on) limit = LIM_TST;
    else         limit = CNT_W'(DET_UNIT) << dly_sel;
  end

  assign cnt_inc = cnt_q + 1'b1;
  assign dip_inc = dip_q + 1'b1;
  assign det_hit = run & tick & any_above & (cnt_inc >= limit);
  assign upd_en  = tick | ~run;

  always_comb begin
    cnt_nx   = cnt_q;
    dip_nx   = dip_q;
    armed_nx = armed_q;
    if (!run || det_hit) begin
      cnt_nx   = '0;
      dip_nx   = '0;
      armed_nx = 1'b0;
    end else if (any_above) begin
      cnt_nx   = cnt_inc;
      dip_nx   = '0;
      armed_nx = 1'b1;
    end else if (armed_q) begin
      if (dip_inc >= LIM_WIN) begin
        cnt_nx   = '0;
        dip_nx   = '0;
        armed_nx = 1'b0;
      end else begin
        dip_nx = dip_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dip_q   <= '0;
      armed_q <= 1'b0;
    end else if (uvlo) begin
      cnt_q   <= '0;
      dip_q   <= '0;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_nx;
      dip_q   <= dip_nx;
      armed_q <= armed_nx;
    end
  end

  AST_DIP_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !uvlo && !any_above && armed_q && (dip_inc < LIM_WIN)) |=> $stable(cnt_q)) // R2
    else $error("count moved during short dip");

  AST_LONG_DIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !any_above && armed_q && (dip_inc >= LIM_WIN)) |=> (cnt_q == '0)) // R3
    else $error("count survived long dip");
endmodule

// File: rtl/ovc_rel_debounce.sv
module ovc_rel_debounce #(
  parameter int REL   = 2,
  parameter int REL_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo,
  input  logic tick,
  input  logic active,
  input  logic all_below,
  output logic rel_hit
);
  localparam logic [REL_W-1:0] LIM_REL = REL_W'(REL);

  logic [REL_W-1:0] rc_q, rc_nx, rc_inc;
  logic             upd_en;

  assign rc_inc  = rc_q + 1'b1;
  assign rel_hit = active & tick & all_below & (rc_inc >= LIM_REL);
  assign upd_en  = tick | ~active;

  always_comb begin
    rc_nx = rc_q;
    if (!active || rel_hit || !all_below) rc_nx = '0;
    else                                  rc_nx = rc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rc_q <= '0;
    else if (uvlo)   rc_q <= '0;
    else if (upd_en) rc_q <= rc_nx;
  end

  AST_REL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active && !all_below) |=> (rc_q == '0)) // R5
    else $error("release debounce not restarted");
endmodule

// File: rtl/ovc_test_latch.sv
module ovc_test_latch #(
  parameter int TST_ENTRY = 64,
  parameter int ENT_W     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo,
  input  logic tick,
  input  logic test_req,
  input  logic clr,
  output logic test_on
);
  localparam logic [ENT_W-1:0] LIM_ENT = ENT_W'(TST_ENTRY);

  logic [ENT_W-1:0] ec_q, ec_nx, ec_inc;
  logic             on_q, on_nx;
  logic             upd_en;

  assign ec_inc  = ec_q + 1'b1;
  assign upd_en  = tick | ~test_req | clr;
  assign test_on = on_q;

  always_comb begin
    ec_nx = ec_q;
    on_nx = on_q;
    if (clr) begin
      on_nx = 1'b0;
      ec_nx = '0;
    end else if (!test_req) begin
      ec_nx = '0;
    end else if (ec_inc >= LIM_ENT) begin
      on_nx = 1'b1;
      ec_nx = '0;
    end else begin
      ec_nx = ec_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ec_q <= '0;
      on_q <= 1'b0;
    end else if (uvlo) begin
      ec_q <= '0;
      on_q <= 1'b0;
    end else if (upd_en) begin
      ec_q <= ec_nx;
      on_q <= on_nx;
    end
  end

  AST_TEST_SET_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> ($past(test_req) && $past(tick))) // R6
    else $error("test latch set without request");

  AST_UVLO_CLEARS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !on_q) // R9
    else $error("test latch survived lockout");
endmodule

// File: rtl/ovc_delay_ctrl.sv
module ovc_delay_ctrl
  import ovc_pkg::*;
#(
  parameter int NCELL     = 5,
  parameter int DET_UNIT  = 1000,
  parameter int TR_WIN    = 12,
  parameter int REL       = 2,
  parameter int TST_ENTRY = 64,
  parameter int TST_DET   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCELL-1:0] above_det,
  input  logic [NCELL-1:0] below_rel,
  input  logic             test_req,
  input  logic             uvlo,
  input  logic [1:0]       dly_sel,
  input  logic             act_low,
  output logic             chg_ctl_o
);
  localparam int CNT_W = $clog2(DET_UNIT * 8 + 1);
  localparam int WIN_W = $clog2(TR_WIN + 1);
  localparam int REL_W = $clog2(REL + 1);
  localparam int ENT_W = $clog2(TST_ENTRY + 1);

  ovc_state_e st_q, st_nx;
  logic       any_above, all_below;
  logic       det_hit, rel_hit, test_on;
  logic       is_over;

  assign any_above = |above_det;
  assign all_below = &below_rel;
  assign is_over   = (st_q == ST_OVER);

  ovc_det_timer #(
    .DET_UNIT (DET_UNIT),
    .TR_WIN   (TR_WIN),
    .TST_DET  (TST_DET),
    .CNT_W    (CNT_W),
    .WIN_W    (WIN_W)
  ) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .uvlo      (uvlo),
    .tick      (tick),
    .run       (~is_over),
    .any_above (any_above),
    .test_on   (test_on),
    .dly_sel   (dly_sel),
    .det_hit   (det_hit)
  );

  ovc_rel_debounce #(
    .REL   (REL),
    .REL_W (REL_W)
  ) u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .uvlo      (uvlo),
    .tick      (tick),
    .active    (is_over),
    .all_below (all_below),
    .rel_hit   (rel_hit)
  );

  ovc_test_latch #(
    .TST_ENTRY (TST_ENTRY),
    .ENT_W     (ENT_W)
  ) u_tst (
    .clk      (clk),
    .rst_n    (rst_n),
    .uvlo     (uvlo),
    .tick     (tick),
    .test_req (test_req),
    .clr      (det_hit),
    .test_on  (test_on)
  );

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_NORMAL: if (det_hit) st_nx = ST_OVER;
      ST_OVER:   if (rel_hit) st_nx = ST_NORMAL;
      default:   st_nx = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= ST_NORMAL;
    else if (uvlo) st_q <= ST_NORMAL;
    else           st_q <= st_nx;
  end

  assign chg_ctl_o = is_over ^ act_low;

  AST_OVER_NEEDS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_over) |-> ($past(any_above) && $past(tick))) // R1
    else $error("overcharge entered without a cell above");

  AST_RELEASE_ALL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(is_over) && !$past(uvlo)) |-> $past(all_below)) // R4
    else $error("release without all cells below");

  AST_TEST_CLR_ON_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_over) |-> !test_on) // R8
    else $error("test latch held into overcharge");

  AST_UVLO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !is_over) // R9
    else $error("lockout did not force normal");
endmodule

// File: tb/tb_ovc_delay_ctrl.sv
`timescale 1ns/1ps
module tb_ovc_delay_ctrl;
  localparam int NCELL = 5;
  localparam int UNIT  = 10;
  localparam int WIN   = 4;
  localparam int RELT  = 3;
  localparam int ENT   = 5;
  localparam int TDET  = 3;

  localparam int NV = 4;
  localparam logic [1:0]       SEL_V  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam int               TICK_V [NV] = '{10, 20, 40, 80};
  localparam logic [NCELL-1:0] CELL_V [NV] = '{5'b00001, 5'b00100, 5'b01000, 5'b10000};

  logic             clk, rst_n, tick, test_req, uvlo, act_low, chg_ctl_o;
  logic [NCELL-1:0] above_det, below_rel;
  logic [1:0]       dly_sel;
  int               n_run, n_fail;

  ovc_delay_ctrl #(
    .NCELL(NCELL), .DET_UNIT(UNIT), .TR_WIN(WIN), .REL(RELT),
    .TST_ENTRY(ENT), .TST_DET(TDET)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .above_det(above_det),
    .below_rel(below_rel), .test_req(test_req), .uvlo(uvlo),
    .dly_sel(dly_sel), .act_low(act_low), .chg_ctl_o(chg_ctl_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic exp);
    n_run++;
    if (chg_ctl_o !== exp) begin
      n_fail++;
      $display("FAIL %s: chg_ctl_o=%b expected %b", req, chg_ctl_o, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic set_above(input logic [NCELL-1:0] c);
    above_det = c;
    below_rel = ~c;
  endtask

  task automatic set_quiet();
    above_det = '0;
    below_rel = '1;
  endtask

  task automatic set_mid();
    above_det = '0;
    below_rel = 5'b11101;
  endtask

  task automatic release_all();
    set_quiet();
    ticks(RELT);
  endtask

  task automatic latch_test();
    test_req = 1'b1;
    ticks(ENT);
    test_req = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; tick = 1'b0; test_req = 1'b0; uvlo = 1'b0;
    act_low = 1'b0; dly_sel = 2'd0;
    above_det = '0; below_rel = '1;
    repeat (3) @(negedge clk);
    check("R11 reset normal", 1'b0);
    act_low = 1'b1; #1;
    check("R10/R11 reset active-low", 1'b1);
    act_low = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: delay codes walked from the table
    for (int v = 0; v < NV; v++) begin
      dly_sel = SEL_V[v];
      set_above(CELL_V[v]);
      ticks(TICK_V[v] - 1);
      check("R1 one tick early", 1'b0);
      ticks(1);
      check("R1 full delay", 1'b1);
      set_quiet();
      ticks(RELT - 1);
      check("R4 release early", 1'b1);
      ticks(1);
      check("R4 release", 1'b0);
    end
    dly_sel = 2'd0;

    // R2: short dip keeps count
    set_above(5'b00010); ticks(6);
    set_quiet();         ticks(WIN - 1);
    set_above(5'b00010); ticks(3);
    check("R2 short dip early", 1'b0);
    ticks(1);
    check("R2 short dip continue", 1'b1);

    // R5: cell between levels restarts debounce
    set_quiet(); ticks(RELT - 1);
    set_mid();   ticks(1);
    check("R5 held over", 1'b1);
    set_quiet(); ticks(RELT - 1);
    check("R5 restarted", 1'b1);
    ticks(1);
    check("R5 release after restart", 1'b0);

    // R3: long dip clears count
    set_above(5'b01000); ticks(6);
    set_quiet();         ticks(WIN);
    set_above(5'b01000); ticks(UNIT - 1);
    check("R3 count cleared", 1'b0);
    ticks(1);
    check("R3 full delay after clear", 1'b1);
    release_all();

    // R6: too-short request does not latch
    test_req = 1'b1; ticks(ENT - 1); test_req = 1'b0;
    set_above(5'b00001); ticks(TDET);
    check("R6 short request no latch", 1'b0);
    set_quiet(); ticks(WIN);

    // R6/R7: latched test mode shortens delay
    latch_test();
    dly_sel = 2'd3;
    set_above(5'b00001); ticks(TDET - 1);
    check("R7 test delay early", 1'b0);
    ticks(1);
    check("R6 R7 test delay", 1'b1);
    dly_sel = 2'd0;
    release_all();

    // R8: latch cleared by overcharge
    set_above(5'b00100); ticks(TDET);
    check("R8 latch cleared", 1'b0);
    ticks(UNIT - TDET);
    check("R8 full delay", 1'b1);
    release_all();

    // R7: reset window not shortened in test mode
    latch_test();
    set_above(5'b10000); ticks(TDET - 1);
    set_quiet();         ticks(WIN - 1);
    check("R7 during dip", 1'b0);
    set_above(5'b10000); ticks(1);
    check("R7 window unchanged", 1'b1);
    release_all();

    // R9: lockout clears latch and overcharge
    latch_test();
    @(negedge clk) uvlo = 1'b1;
    @(negedge clk) uvlo = 1'b0;
    set_above(5'b00001); ticks(TDET);
    check("R9 latch cleared by lockout", 1'b0);
    ticks(UNIT - TDET);
    check("R9 normal delay", 1'b1);
    act_low = 1'b1; #1;
    check("R10 active-low over", 1'b0);
    act_low = 1'b0;
    @(negedge clk) uvlo = 1'b1;
    @(negedge clk) uvlo = 1'b0;
    check("R9 lockout forces normal", 1'b0);
    ticks(UNIT - 1);
    check("R9 count cleared", 1'b0);
    ticks(1);
    check("R9 redetect", 1'b1);
    release_all();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule